// File: doc/BRIEF.md
# Pulse-Width Input Meter

This block measures the period and the high time of one pulse-width-modulated signal. The signal comes from one of two input pins, is brought into the clock domain and feeds two capture channels. Both channels latch one free-running timer: the first on rising edges, the second on falling edges. A start command arms a single measurement. The block first works out a clock prescaler that fits the caller's timeout window into one counter revolution. It then takes two snapshots, each on a rising edge, and reports the raw period and duty counts in prescaled ticks. The measurement ends with either a done pulse or a timeout pulse.

The snapshot copy lags each rising edge by a fixed number of clocks, in the way a transfer engine would. A falling edge in that gap overwrites the falling-edge capture before it is copied, and the arithmetic corrects for this. Differences taken across a counter wrap are also corrected. A measurement request is refused while the timer is in use for PWM output, because the two uses share the prescaler.

Top module: `pwm_meter`

## Requirements
- R1: After reset, `busy_o`, `running_o`, `done_o` and `timeout_o` are 0, and `period_o`, `duty_o` and `psc_o` are 0.
- R2: `sel_i` = 0 measures `pin0_i` and `sel_i` = 1 measures `pin1_i`. The unselected pin has no effect on the results.
- R3: On an accepted start, the prescaler `psc_o` becomes the smallest p in 0..2^PSC_W-1 for which `window_i` <= `max_reload_i`*(p+1). If no such p exists, it saturates at 2^PSC_W-1.
- R4: The counter restarts at 0 when measurement begins. It advances once every p+1 clocks and steps from `max_reload_i`-1 back to 0. `period_o` is the number of ticks between two consecutive rising edges of the selected input.
- R5: `duty_o` is the number of ticks from the first of those rising edges to the falling edge that follows it.
- R6: When a later capture is below the first one, the difference is (`max_reload_i` - first) + later. Results are therefore exact across a counter wrap.
- R7: If the high time is shorter than SNAP_DLY clocks, the falling edge after the second rising edge overwrites the falling capture before the snapshot. The duty is then corrected by subtracting the period, and `duty_o` still equals the high time.
- R8: With NUM_CH = 1, `duty_o` is always 0 and `period_o` is still reported.
- R9: A start while `out_active_i` = 1 gives a one-cycle `busy_o` pulse and starts no measurement (`running_o` stays 0).
- R10: If the second snapshot has not arrived within 2*`max_reload_i` prescaled ticks of the start of counting, `timeout_o` pulses for one cycle, `done_o` stays 0 and the block returns to idle.
- R11: `done_o` is a one-cycle pulse. `running_o` is 0 in that same cycle. `period_o`, `duty_o` and `psc_o` hold their values afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Arms one measurement (sampled while idle) |
| out_active_i | input | 1 | Timer is driving a PWM output; refuse measurements |
| sel_i | input | 1 | Input select: 0 = pin0_i, 1 = pin1_i |
| pin0_i | input | 1 | First asynchronous PWM input |
| pin1_i | input | 1 | Second asynchronous PWM input |
| max_reload_i | input | CNT_W | Counter modulus (must be at least 2) |
| window_i | input | WIN_W | Timeout window in clocks, used for the prescaler choice |
| busy_o | output | 1 | One-cycle refusal pulse |
| running_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | One-cycle timeout pulse |
| psc_o | output | PSC_W | Prescaler used by the last measurement |
| period_o | output | CNT_W | Period in prescaled ticks |
| duty_o | output | CNT_W | High time in prescaled ticks |

## Verification
The hardest case to reach is the overwrite race. It needs a falling edge that lands inside the few clocks between the second rising edge and the snapshot copy. The stimulus reaches it with a prescaler of 0 and pulses only one or two clocks high. Wrapped differences are forced without looking inside the block. The bench waits for a rising edge of the selected pin and starts a few clocks after it, so the first capture falls late in the revolution. With a period of two thirds of the modulus, the second capture then has to wrap.

// File: rtl/pwm_meter_pkg.sv
package pwm_meter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_RUN    = 2'd2
  } meter_state_e;
endpackage

// File: rtl/pwm_meter_sync.sv
// Two-flop synchroniser followed by an edge detector on the synced level.
module pwm_meter_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/pwm_meter_timebase.sv
// Prescaled up-counter, counting 0 .. max_reload-1 and then back to 0.
module pwm_meter_timebase #(
  parameter int CNT_W = 8,
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] max_reload,
  output logic [CNT_W-1:0] cnt,
  output logic             tick
);
  logic [PSC_W-1:0] div_q;

  assign tick = enable && (div_q == psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt   <= '0;
    end else if (clear) begin
      div_q <= '0;
      cnt   <= '0;
    end else if (enable) begin
      if (tick) begin
        div_q <= '0;
        cnt   <= (cnt == max_reload - CNT_W'(1)) ? '0 : cnt + CNT_W'(1);
      end else begin
        div_q <= div_q + PSC_W'(1);
      end
    end
  end
endmodule

// File: rtl/pwm_meter.sv
module pwm_meter
  import pwm_meter_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WIN_W    = 16,
  parameter int PSC_W    = 4,
  parameter int NUM_CH   = 2,
  parameter int SNAP_DLY = 3   // clocks from rising edge to snapshot copy, >= 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             out_active_i,
  input  logic             sel_i,
  input  logic             pin0_i,
  input  logic             pin1_i,
  input  logic [CNT_W-1:0] max_reload_i,
  input  logic [WIN_W-1:0] window_i,
  output logic             busy_o,
  output logic             running_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic [PSC_W-1:0] psc_o,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] duty_o
);
  localparam int ACC_W = ((CNT_W + PSC_W) > WIN_W ? (CNT_W + PSC_W) : WIN_W) + 1;
  localparam int TO_W  = CNT_W + 1;
  localparam logic [PSC_W-1:0] PSC_MAX = '1;

  // Modular difference from first to later on a counter of modulus m (R6)
  function automatic logic [CNT_W-1:0] wrap_diff(input logic [CNT_W-1:0] first,
                                                 input logic [CNT_W-1:0] later,
                                                 input logic [CNT_W-1:0] m);
    return (later >= first) ? later - first : (m - first) + later;
  endfunction

  // Race fix: subtract the period from a duty that overran it (R7)
  function automatic logic [CNT_W-1:0] fix_duty(input logic [CNT_W-1:0] raw,
                                                input logic [CNT_W-1:0] per);
    return (raw > per) ? raw - per : raw;
  endfunction

  meter_state_e     state_q;
  logic [PSC_W-1:0] psc_q;
  logic [ACC_W-1:0] acc_q;
  logic [TO_W-1:0]  tout_q;
  logic             nsnap_q;
  logic [CNT_W-1:0] first_a_q, cap_a_q, cap_b;
  logic [CNT_W-1:0] period_q, duty_q;
  logic             done_q, tmo_q, busy_q;
  logic [SNAP_DLY-1:0] snap_sr;

  // Internal events brought out as named wires
  logic             pin_sel_w, rise_w, fall_w, tick_w, snap_ev_w, run_w;
  logic [CNT_W-1:0] cnt_w, per_w, dut_w;
  logic [ACC_W-1:0] m_ext, win_ext;
  logic [TO_W-1:0]  tout_lim;

  assign pin_sel_w = sel_i ? pin1_i : pin0_i;
  assign run_w     = (state_q == ST_RUN);
  assign m_ext     = ACC_W'(max_reload_i);
  assign win_ext   = ACC_W'(window_i);
  assign tout_lim  = {max_reload_i, 1'b0} - TO_W'(1);
  assign snap_ev_w = snap_sr[SNAP_DLY-1];

  pwm_meter_sync u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_sel_w),
    .rise (rise_w),
    .fall (fall_w)
  );

  pwm_meter_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!run_w),
    .enable    (run_w),
    .psc       (psc_q),
    .max_reload(max_reload_i),
    .cnt       (cnt_w),
    .tick      (tick_w)
  );

  // Capture channel on rising edges, delayed snapshot strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a_q <= '0;
      snap_sr <= '0;
    end else if (!run_w) begin
      snap_sr <= '0;
    end else begin
      if (rise_w) cap_a_q <= cnt_w;
      snap_sr <= {snap_sr[SNAP_DLY-2:0], rise_w};
    end
  end

  // Falling-edge capture channel only when two channels exist (R8)
  generate
    if (NUM_CH > 1) begin : g_dual
      logic [CNT_W-1:0] cap_b_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cap_b_q <= '0;
        else if (run_w && fall_w)  cap_b_q <= cnt_w;
      end
      assign cap_b = cap_b_q;
      assign dut_w = fix_duty(wrap_diff(first_a_q, cap_b, max_reload_i), per_w);
    end else begin : g_single
      assign cap_b = '0;
      assign dut_w = '0;
    end
  endgenerate

  assign per_w = wrap_diff(first_a_q, cap_a_q, max_reload_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      psc_q     <= '0;
      acc_q     <= '0;
      tout_q    <= '0;
      nsnap_q   <= 1'b0;
      first_a_q <= '0;
      period_q  <= '0;
      duty_q    <= '0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      busy_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (out_active_i) begin
              busy_q <= 1'b1;
            end else begin
              state_q <= ST_SEARCH;
              psc_q   <= '0;
              acc_q   <= m_ext;
            end
          end
        end
        ST_SEARCH: begin
          if (win_ext > acc_q && psc_q != PSC_MAX) begin
            psc_q <= psc_q + PSC_W'(1);
            acc_q <= acc_q + m_ext;
          end else begin
            state_q <= ST_RUN;
            nsnap_q <= 1'b0;
            tout_q  <= '0;
          end
        end
        ST_RUN: begin
          if (snap_ev_w && nsnap_q) begin
            period_q <= per_w;
            duty_q   <= dut_w;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            if (snap_ev_w) begin
              first_a_q <= cap_a_q;
              nsnap_q   <= 1'b1;
            end
            if (tick_w) begin
              if (tout_q == tout_lim) begin
                tmo_q   <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                tout_q <= tout_q + TO_W'(1);
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = busy_q;
  assign running_o = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = tmo_q;
  assign psc_o     = psc_q;
  assign period_o  = period_q;
  assign duty_o    = duty_q;
endmodule

// File: rtl/pwm_meter_chk.sv
module pwm_meter_chk #(
  parameter int CNT_W  = 8,
  parameter int NUM_CH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             out_active_i,
  input logic             busy_o,
  input logic             running_o,
  input logic             done_o,
  input logic             timeout_o,
  input logic [CNT_W-1:0] period_o,
  input logic [CNT_W-1:0] duty_o,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W-1:0] max_reload_i,
  input logic             rise_w,
  input logic             fall_w
);
  AST_REFUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !running_o);                                            // R9
  AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running_o) |-> ($past(start_i) && !$past(out_active_i)));    // R9
  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));                                           // R10
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || timeout_o) |-> !running_o);                             // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                               // R11
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |-> (cnt_w < max_reload_i));                             // R4
  AST_DUTY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (duty_o <= period_o));                                  // R7
  AST_ONE_CH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (NUM_CH > 1 || duty_o == '0));                          // R8
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_w && fall_w));                                              // R5
endmodule

bind pwm_meter pwm_meter_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .out_active_i(out_active_i),
  .busy_o      (busy_o),
  .running_o   (running_o),
  .done_o      (done_o),
  .timeout_o   (timeout_o),
  .period_o    (period_o),
  .duty_o      (duty_o),
  .cnt_w       (cnt_w),
  .max_reload_i(max_reload_i),
  .rise_w      (rise_w),
  .fall_w      (fall_w)
);

// File: tb/test_pwm_meter.sv
module test_pwm_meter;
  localparam int CNT_W = 8, WIN_W = 16, PSC_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, out_active = 1'b0, sel = 1'b0;
  logic pin0 = 1'b0, pin1 = 1'b0;
  logic [CNT_W-1:0] max_reload = 8'd40;
  logic [WIN_W-1:0] window = 16'd40;
  logic busy, running, done, tmo, done1, tmo1, busy1, running1;
  logic [PSC_W-1:0] psc, psc1;
  logic [CNT_W-1:0] period, duty, period1, duty1;

  int total = 0, bad = 0;
  int a_per = 30, a_hi = 11, a_ph = 0, a_on = 1;
  int b_ph = 0;

  always #5 clk = ~clk;

  pwm_meter i_pwm_meter (
    .clk(clk), .rst_n(rst_n), .start_i(start), .out_active_i(out_active),
    .sel_i(sel), .pin0_i(pin0), .pin1_i(pin1), .max_reload_i(max_reload),
    .window_i(window), .busy_o(busy), .running_o(running), .done_o(done),
    .timeout_o(tmo), .psc_o(psc), .period_o(period), .duty_o(duty));

  pwm_meter #(.NUM_CH(1)) i_pwm_meter_one (
    .clk(clk), .rst_n(rst_n), .start_i(start), .out_active_i(out_active),
    .sel_i(sel), .pin0_i(pin0), .pin1_i(pin1), .max_reload_i(max_reload),
    .window_i(window), .busy_o(busy1), .running_o(running1), .done_o(done1),
    .timeout_o(tmo1), .psc_o(psc1), .period_o(period1), .duty_o(duty1));

  // Waveform generators, updated just after each rising clock edge
  initial forever begin
    @(posedge clk); #1;
    if (a_on != 0) begin
      pin0 = (a_ph < a_hi);
      a_ph = (a_ph + 1 >= a_per) ? 0 : a_ph + 1;
    end else begin
      pin0 = 1'b0;
      a_ph = 0;
    end
    pin1 = (b_ph < 8);
    b_ph = (b_ph + 1 >= 24) ? 0 : b_ph + 1;
  end

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int ref_psc(input int m, input int w);
    int p = 0;
    while (p < 15 && w > m * (p + 1)) p++;
    return p;
  endfunction

  task automatic pulse_start(output int cycles);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cycles = 1;
    for (int n = 0; n < 20000; n++) begin
      if (done || tmo) break;
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic measure(input int m, input int win, input int pclk, input int hclk,
                         input logic s, input int exp_p, input int exp_d, input string tag);
    int cyc;
    max_reload = CNT_W'(m);
    window = WIN_W'(win);
    sel = s;
    @(negedge clk);
    a_per = pclk; a_hi = hclk; a_ph = 0; a_on = 1;
    repeat (2 * pclk + 60) @(negedge clk);
    if (s) @(posedge pin1); else @(posedge pin0);
    repeat (6) @(negedge clk);
    pulse_start(cyc);
    chk({tag, " R10 no timeout"}, int'(tmo), 0);
    chk({tag, " R11 done pulse"}, int'(done), 1);
    chk({tag, " R11 running low at done"}, int'(running), 0);
    chk({tag, " R3 prescaler"}, int'(psc), ref_psc(m, win));
    chk({tag, " R4 period"}, int'(period), exp_p);
    chk({tag, " R5 duty"}, int'(duty), exp_d);
    chk({tag, " R8 single-channel period"}, int'(period1), exp_p);
    chk({tag, " R8 single-channel duty zero"}, int'(duty1), 0);
    @(negedge clk);
    chk({tag, " R11 done one cycle"}, int'(done), 0);
    chk({tag, " R11 period held"}, int'(period), exp_p);
  endtask

  initial begin
    int mlist[3];
    int m, win, pt, ht, cyc;
    mlist[0] = 40; mlist[1] = 63; mlist[2] = 150;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 running", int'(running), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 timeout", int'(tmo), 0);
    chk("R1 period", int'(period), 0);
    chk("R1 duty", int'(duty), 0);
    chk("R1 psc", int'(psc), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 refusal while the timer drives an output
    out_active = 1'b1;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9 busy pulse", int'(busy), 1);
    chk("R9 not running", int'(running), 0);
    @(negedge clk);
    chk("R9 busy clears", int'(busy), 0);
    chk("R9 still idle", int'(running), 0);
    out_active = 1'b0;

    // Sweep: modulus x prescaler x waveform; second waveform forces wrap (R6)
    for (int i = 0; i < 3; i++) begin
      for (int p = 0; p < 4; p++) begin
        for (int w = 0; w < 2; w++) begin
          m   = mlist[i];
          win = (p == 0) ? m : m * p + 1;
          pt  = (w == 0) ? m / 4 : (2 * m) / 3;
          ht  = (w == 0) ? 3 : m / 3;
          measure(m, win, pt * (p + 1), ht * (p + 1), 1'b0, pt, ht,
                  (w == 0) ? "sweep R4" : "wrap R6");
        end
      end
    end

    // R7 overwrite race: high time shorter than the snapshot lag
    measure(100, 100, 20, 1, 1'b0, 20, 1, "race R7 h1");
    measure(100, 100, 20, 2, 1'b0, 20, 2, "race R7 h2");

    // R2 select second pin (fixed 24/8) while pin0 carries 30/11
    measure(100, 100, 30, 11, 1'b1, 24, 8, "select R2 pin1");
    measure(100, 100, 30, 11, 1'b0, 30, 11, "select R2 pin0");

    // R10 timeout with a silent input: 2*40 ticks at p=0
    sel = 1'b0; a_on = 0; max_reload = 8'd40; window = 16'd40;
    repeat (5) @(negedge clk);
    pulse_start(cyc);
    chk("R10 timeout flag", int'(tmo), 1);
    chk("R10 no done", int'(done), 0);
    chk("R10 back to idle", int'(running), 0);
    chk("R10 timing lower bound", int'(cyc >= 80), 1);
    chk("R10 timing upper bound", int'(cyc <= 90), 1);

    // R3 prescaler saturation
    window = 16'd40000;
    pulse_start(cyc);
    chk("R3 psc saturates", int'(psc), 15);
    chk("R3 saturated run times out", int'(tmo), 1);
    @(negedge clk);
    chk("R11 psc held", int'(psc), 15);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule